// File: doc/BRIEF.md
# Accumulator Arithmetic-Logic Unit with Carry and Zero Flags

This block keeps an 8-bit accumulator register together with a carry flag and a zero flag, and it contains the combinational logic that computes their next values. A control unit supplies a 3-bit function code and an accumulator write enable. The second operand is one of two bytes: an immediate byte or a register-file byte. A select input picks between them.

The block performs eight functions. These are load, add-with-carry, bitwise OR, bitwise AND, bitwise XOR, a swap of the two nibbles, carry clear and carry set. The function code is held in an enumerated type and decoded with a unique case. There is no sequencing state: every function completes in a single write cycle, and when the enable is low the register holds its value. The register process is separate from the next-value process. The accumulator and both flags are visible on output ports at all times.

Top module: `acc_unit`

## Requirements
- R1: While rst_n is low, the accumulator, carry and zero outputs are all 0 on the next rising edge, and they stay 0 until rst_n is released.
- R2: When acc_we is low at a rising edge, the accumulator, carry and zero keep their values whatever the function code and operands are.
- R3: Function code 0 (load) with acc_we high writes the operand into the accumulator and leaves the carry unchanged.
- R4: Function code 1 (add-with-carry) with acc_we high forms the 9-bit sum accumulator + operand + carry. The sum's bit 8 becomes the carry and its bits 7..0 become the accumulator.
- R5: Function codes 2 (OR), 3 (AND) and 4 (XOR) with acc_we high write the bitwise combination of the accumulator and the operand into the accumulator and leave the carry unchanged.
- R6: Function code 5 (swap) with acc_we high writes {A[3:0], A[7:4]} into the accumulator and leaves the carry unchanged.
- R7: Function codes 6 (clear carry) and 7 (set carry) with acc_we high set the carry to 0 or to 1. The accumulator and the zero flag do not change.
- R8: Every write that changes the accumulator (codes 0 to 5) sets the zero flag to 1 exactly when the new accumulator value is 0.
- R9: When opnd_sel is 1 the operand is imm_byte; when opnd_sel is 0 the operand is reg_byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_we | input | 1 | Write enable for the accumulator and the flags |
| func | input | 3 | Function code (0 load, 1 add-with-carry, 2 OR, 3 AND, 4 XOR, 5 swap, 6 clear carry, 7 set carry) |
| opnd_sel | input | 1 | Operand source: 1 selects the immediate byte, 0 selects the register byte |
| imm_byte | input | 8 | Immediate operand |
| reg_byte | input | 8 | Register-file operand |
| acc_q | output | 8 | Accumulator value |
| carry_q | output | 1 | Carry flag |
| zero_q | output | 1 | Zero flag |

## Verification
Every result appears exactly one rising edge after the inputs that cause it, because only one register lies between the inputs and the outputs. The bench changes inputs on the falling edge. It then waits for the next rising edge and reads the outputs on the falling edge that follows, so each value is sampled half a period after it settles. Hold and reset behaviour are checked the same way: the bench reads one falling edge after the enable is held low or reset is asserted, and reads again after several further edges.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int DATA_W = 8;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [2:0] {
        FN_LOAD = 3'd0,
        FN_ADDC = 3'd1,
        FN_OR   = 3'd2,
        FN_AND  = 3'd3,
        FN_XOR  = 3'd4,
        FN_SWAP = 3'd5,
        FN_CLRC = 3'd6,
        FN_SETC = 3'd7
    } acc_fn_e;
endpackage

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] cur_acc,
    input  logic         cur_carry,
    input  logic [W-1:0] opnd,
    input  acc_fn_e      fn,
    output logic [W-1:0] nxt_acc,
    output logic         nxt_carry,
    output logic         acc_wr
);
    localparam int H = W / 2;

    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, cur_acc} + {1'b0, opnd} + {{W{1'b0}}, cur_carry};
    end

    always_comb begin
        nxt_acc   = cur_acc;
        nxt_carry = cur_carry;
        acc_wr    = 1'b1;
        unique case (fn)
            FN_LOAD: nxt_acc = opnd;
            FN_ADDC: {nxt_carry, nxt_acc} = sum;
            FN_OR:   nxt_acc = cur_acc | opnd;
            FN_AND:  nxt_acc = cur_acc & opnd;
            FN_XOR:  nxt_acc = cur_acc ^ opnd;
            FN_SWAP: nxt_acc = {cur_acc[H-1:0], cur_acc[W-1:H]};
            FN_CLRC: begin
                nxt_carry = 1'b0;
                acc_wr    = 1'b0;
            end
            FN_SETC: begin
                nxt_carry = 1'b1;
                acc_wr    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/acc_regs.sv
module acc_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         acc_wr,
    input  logic [W-1:0] nxt_acc,
    input  logic         nxt_carry,
    output logic [W-1:0] acc_r,
    output logic         carry_r,
    output logic         zero_r
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_r   <= '0;
            carry_r <= 1'b0;
            zero_r  <= 1'b0;
        end else if (we) begin
            carry_r <= nxt_carry;
            if (acc_wr) begin
                acc_r  <= nxt_acc;
                zero_r <= (nxt_acc == '0);
            end
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(acc_r) && $stable(carry_r) && $stable(zero_r)));

    assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && acc_wr) |=> (zero_r == (acc_r == '0)));

    assert_no_acc_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !acc_wr) |=> ($stable(acc_r) && $stable(zero_r)));
endmodule

// File: rtl/acc_unit.sv
module acc_unit
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_we,
    input  logic [2:0]        func,
    input  logic              opnd_sel,
    input  logic [DATA_W-1:0] imm_byte,
    input  logic [DATA_W-1:0] reg_byte,
    output logic [DATA_W-1:0] acc_q,
    output logic              carry_q,
    output logic              zero_q
);
    acc_fn_e           fn;
    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] nxt_acc;
    logic              nxt_carry;
    logic              acc_wr;

    always_comb begin
        fn   = acc_fn_e'(func);
        opnd = opnd_sel ? imm_byte : reg_byte;
    end

    acc_alu_core #(.W(DATA_W)) u_core (
        .cur_acc   (acc_q),
        .cur_carry (carry_q),
        .opnd      (opnd),
        .fn        (fn),
        .nxt_acc   (nxt_acc),
        .nxt_carry (nxt_carry),
        .acc_wr    (acc_wr)
    );

    acc_regs #(.W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (acc_we),
        .acc_wr    (acc_wr),
        .nxt_acc   (nxt_acc),
        .nxt_carry (nxt_carry),
        .acc_r     (acc_q),
        .carry_r   (carry_q),
        .zero_r    (zero_q)
    );

    assert_addc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && func == 3'd1) |=>
        ({carry_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(opnd_sel ? imm_byte : reg_byte)}
                              + {{DATA_W{1'b0}}, $past(carry_q)})));

    assert_keep_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && (func == 3'd0 || func == 3'd2 || func == 3'd3 || func == 3'd4 || func == 3'd5))
        |=> $stable(carry_q));

    assert_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && func == 3'd5) |=> (acc_q == {$past(acc_q[HALF_W-1:0]), $past(acc_q[DATA_W-1:HALF_W])}));

    assert_setc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && func == 3'd7) |=> carry_q);

    assert_clrc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && func == 3'd6) |=> !carry_q);
endmodule

// File: tb/acc_unit_tb.sv
module acc_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_we = 1'b0;
    logic [2:0] func = 3'd0;
    logic       opnd_sel = 1'b0;
    logic [7:0] imm_byte = 8'h00;
    logic [7:0] reg_byte = 8'h00;
    logic [7:0] acc_q;
    logic       carry_q;
    logic       zero_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    acc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .acc_we(acc_we), .func(func),
        .opnd_sel(opnd_sel), .imm_byte(imm_byte), .reg_byte(reg_byte),
        .acc_q(acc_q), .carry_q(carry_q), .zero_q(zero_q)
    );

    // {func, opnd_sel, imm, reg, expected acc, expected carry, expected zero}
    localparam int NV = 17;
    localparam logic [29:0] VEC [NV] = '{
        {3'd0, 1'b1, 8'h3C, 8'hFF, 8'h3C, 1'b0, 1'b0},
        {3'd7, 1'b1, 8'h00, 8'h00, 8'h3C, 1'b1, 1'b0},
        {3'd1, 1'b0, 8'hAA, 8'h10, 8'h4D, 1'b0, 1'b0},
        {3'd1, 1'b1, 8'hB3, 8'h00, 8'h00, 1'b1, 1'b1},
        {3'd1, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b1},
        {3'd2, 1'b0, 8'h00, 8'h81, 8'h81, 1'b1, 1'b0},
        {3'd3, 1'b1, 8'h0F, 8'hF0, 8'h01, 1'b1, 1'b0},
        {3'd4, 1'b0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1},
        {3'd6, 1'b1, 8'h55, 8'h55, 8'h00, 1'b0, 1'b1},
        {3'd0, 1'b0, 8'h11, 8'hA5, 8'hA5, 1'b0, 1'b0},
        {3'd5, 1'b1, 8'hFF, 8'hFF, 8'h5A, 1'b0, 1'b0},
        {3'd7, 1'b0, 8'h00, 8'h00, 8'h5A, 1'b1, 1'b0},
        {3'd4, 1'b1, 8'hFF, 8'h00, 8'hA5, 1'b1, 1'b0},
        {3'd1, 1'b1, 8'h5A, 8'h00, 8'h00, 1'b1, 1'b1},
        {3'd7, 1'b1, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1},
        {3'd0, 1'b1, 8'h00, 8'h77, 8'h00, 1'b1, 1'b1},
        {3'd1, 1'b1, 8'h7F, 8'h00, 8'h80, 1'b0, 1'b0}
    };

    function automatic string req_of(input logic [2:0] f);
        case (f)
            3'd0:          return "R3/R9";
            3'd1:          return "R4/R8";
            3'd2, 3'd3, 3'd4: return "R5/R8";
            3'd5:          return "R6";
            default:       return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] ea, input logic ec, input logic ez);
        n_checks++;
        if (acc_q !== ea || carry_q !== ec || zero_q !== ez) begin
            n_fail++;
            $display("FAIL %s: acc=%02h c=%0b z=%0b expected acc=%02h c=%0b z=%0b",
                     req, acc_q, carry_q, zero_q, ea, ec, ez);
        end
    endtask

    task automatic step(input logic we, input logic [2:0] f, input logic s,
                        input logic [7:0] im, input logic [7:0] rg);
        acc_we = we; func = f; opnd_sel = s; imm_byte = im; reg_byte = rg;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: acc=%02h expected run to finish", acc_q);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][29:27], VEC[i][26], VEC[i][25:18], VEC[i][17:10]);
            check(req_of(VEC[i][29:27]), VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R2: enable low, every function code offered, nothing changes
        for (int f = 0; f < 8; f++) begin
            step(1'b0, 3'(f), 1'b1, 8'h00, 8'hFF);
        end
        check("R2 hold with we low", 8'h80, 1'b0, 1'b0);

        // R9: same func, differing operands, sel picks register byte
        step(1'b1, 3'd0, 1'b0, 8'h00, 8'h42);
        check("R9 register operand", 8'h42, 1'b0, 1'b0);

        // R1: reset mid-run overrides a write
        step(1'b1, 3'd7, 1'b1, 8'h00, 8'h00);
        check("R7 set before reset", 8'h42, 1'b1, 1'b0);
        rst_n = 1'b0;
        step(1'b1, 3'd0, 1'b1, 8'hEE, 8'hEE);
        check("R1 reset mid-run", 8'h00, 1'b0, 1'b0);
        step(1'b1, 3'd7, 1'b1, 8'hEE, 8'hEE);
        check("R1 reset held", 8'h00, 1'b0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule